// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block is an asynchronous FIFO for 9-bit words. The write port and the read port run on unrelated clocks. Each pointer crosses to the other domain as a Gray code through a two-stage synchroniser. The block drives active-low status flags: full, empty, almost-full, almost-empty and half-full. The almost-full and almost-empty thresholds come from static offset inputs, `af_ofs_i` (m) and `ae_ofs_i` (n).

A static mode pin selects between two read modes:

- **Standard mode.** A read strobe fetches the next word into `rdata_o` on the read edge.
- **Fall-through mode.** The head word moves into an output register by itself, so it is visible before any read. That register adds one word of capacity, and every threshold moves up by one word.

Each flag is updated only on the clock of the domain that computes it. A flag that depends on the other side's pointer sees that pointer a few cycles late, so it deasserts a cycle or two after the change on the other side.

Top module: `dc_fifo_flags`

## Requirements
- R1: During and after reset, before any write:
  - `empty_no` and `pae_no` are low (asserted).
  - `full_no`, `paf_no` and `hf_no` are high.
  - Every flag is active low.
- R2: A word is written on a rising `wclk_i` edge only while `wen_ni` is low. Words leave in the order they were written.
- R3: A write while `full_no` is low is dropped, and a read while `empty_no` is low is dropped. Neither one changes the stored contents or the pointers.
- R4: Let D = 2^AW. Capacity is D words with `fwft_i`=0 and D+1 words with `fwft_i`=1. `full_no` is low exactly when occupancy equals that capacity.
- R5: `paf_no` is low when occupancy is at least D−m (standard mode) or D+1−m (fall-through mode). It is high below that level, and it changes only on `wclk_i` edges.
- R6: `pae_no` is low when occupancy is at most n (standard mode) or n+1 (fall-through mode). It is high above that level, and it changes only on `rclk_i` edges.
- R7: `hf_no` is low when occupancy is at least D/2+1 (standard mode) or D/2+2 (fall-through mode). It is high below that level.
- R8: How `rdata_o` and `empty_no` behave depends on the mode:
  - Standard mode: `rdata_o` takes the word read on the read edge, and `empty_no` is high whenever memory holds a word.
  - Fall-through mode: `rdata_o` shows the head word before any read, `empty_no` is high while the output register holds a word, and that word stays put until it is read.
- R9: The pointer sent to the other clock domain changes by at most one bit per cycle of its own clock.
- R10: After a change on the opposite side, every flag reaches its settled value within four cycles of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low, for both domains |
| fwft_i | input | 1 | Static mode select: 1 = fall-through mode, 0 = standard mode |
| af_ofs_i | input | AW | Almost-full offset m (static) |
| ae_ofs_i | input | AW | Almost-empty offset n (static) |
| wen_ni | input | 1 | Write enable, active low |
| wdata_i | input | DW | Write data |
| full_no | output | 1 | Full flag, active low |
| paf_no | output | 1 | Almost-full flag, active low |
| hf_no | output | 1 | Half-full flag, active low |
| ren_ni | input | 1 | Read enable, active low |
| rdata_o | output | DW | Read data |
| empty_no | output | 1 | Empty flag, active low |
| pae_no | output | 1 | Almost-empty flag, active low |

## Verification
The bench exercises the FIFO with four input patterns:

- **Slow fill to capacity.** Each write is followed by a settle time, and all five flags are checked at every occupancy level. This separates each threshold from its neighbours and separates the two modes, which differ by exactly one word.
- **Slow drain to empty.** The same per-level checks confirm that each flag deasserts at the right level on the way down, not only that it asserts on the way up.
- **Write into a full FIFO and read from an empty one.** The word order seen afterwards shows whether a dropped operation moved a pointer.
- **Concurrent streaming.** Both sides run at once on unrelated clocks, with backpressure from the flags. This exercises the Gray crossing under live pointer changes.

Four offset and mode combinations are run, including the zero offsets, where almost-full coincides with full.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  localparam int unsigned DATA_W = 9;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int s = 1; s < 32; s = s * 2) b = b ^ (b >> s);
    return b;
  endfunction
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dcf_wr_ctl.sv
`timescale 1ns/1ps
module dcf_wr_ctl #(
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wen_ni,
  input  logic [AW-1:0] af_ofs_i,
  input  logic [AW:0]   rgray_s_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wgray_o,
  output logic          full_no,
  output logic          paf_no,
  output logic          hf_no
);
  localparam int unsigned PW = AW + 1;
  localparam logic [PW-1:0] DEPTH   = PW'(1 << AW);
  localparam logic [PW-1:0] HALF_UP = PW'((1 << AW) / 2 + 1);

  logic [PW-1:0] wbin_q, wbin_d, rbin_s, cnt_d, af_lvl;

  assign we_o    = !wen_ni && full_no;
  assign wbin_d  = wbin_q + PW'(we_o);
  assign rbin_s  = PW'(dcf_pkg::gray2bin(32'(rgray_s_i)));
  assign cnt_d   = wbin_d - rbin_s;
  assign af_lvl  = DEPTH - PW'(af_ofs_i);
  assign waddr_o = wbin_q[AW-1:0];

  // flags registered from next-state count: updated on the write edge itself
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_o <= '0;
      full_no <= 1'b1;
      paf_no  <= 1'b1;
      hf_no   <= 1'b1;
    end else begin
      wbin_q  <= wbin_d;
      wgray_o <= PW'(dcf_pkg::bin2gray(32'(wbin_d)));
      full_no <= (cnt_d != DEPTH);
      paf_no  <= (cnt_d < af_lvl);
      hf_no   <= (cnt_d < HALF_UP);
    end
  end

  a_r9_wgray_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wgray_o ^ $past(wgray_o)));
  a_r4_fill_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (PW'(wbin_q - rbin_s) <= DEPTH));
  a_r5_full_in_af: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_no |-> !paf_no);
  a_r7_full_in_hf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_no |-> !hf_no);
endmodule

// File: rtl/dcf_rd_ctl.sv
`timescale 1ns/1ps
module dcf_rd_ctl #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ren_ni,
  input  logic          fwft_i,
  input  logic [AW-1:0] ae_ofs_i,
  input  logic [AW:0]   wgray_s_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic [DW-1:0] rdata_o,
  output logic          empty_no,
  output logic          pae_no
);
  localparam int unsigned PW = AW + 1;
  localparam int unsigned CW = AW + 2;
  localparam logic [PW-1:0] DEPTH = PW'(1 << AW);

  logic [PW-1:0] rbin_q, rbin_d, wbin_s;
  logic [CW-1:0] tot_d, ae_lvl;
  logic          mem_ne, adv, ov_q, ov_d;

  assign wbin_s = PW'(dcf_pkg::gray2bin(32'(wgray_s_i)));
  assign mem_ne = (rbin_q != wbin_s);

  // fall-through: output register refills whenever it is empty or being read
  always_comb begin
    if (fwft_i) begin
      adv  = mem_ne && (!ov_q || !ren_ni);
      ov_d = adv || (ov_q && ren_ni);
    end else begin
      adv  = mem_ne && !ren_ni;
      ov_d = 1'b0;
    end
  end

  assign rbin_d   = rbin_q + PW'(adv);
  assign tot_d    = CW'(PW'(wbin_s - rbin_d)) + CW'(ov_d);
  assign ae_lvl   = CW'(ae_ofs_i) + CW'(fwft_i);
  assign raddr_o  = rbin_q[AW-1:0];
  assign empty_no = fwft_i ? ov_q : mem_ne;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_o <= '0;
      ov_q    <= 1'b0;
      rdata_o <= '0;
      pae_no  <= 1'b0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_o <= PW'(dcf_pkg::bin2gray(32'(rbin_d)));
      ov_q    <= ov_d;
      if (adv) rdata_o <= mem_rdata_i;
      pae_no  <= (tot_d > ae_lvl);
    end
  end

  a_r9_rgray_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rgray_o ^ $past(rgray_o)));
  a_r3_no_underrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (PW'(wbin_s - rbin_q) <= DEPTH));
  a_r6_empty_in_ae: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty_no |-> !pae_no);
  a_r8_head_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwft_i && empty_no && ren_ni) |=> $stable(rdata_o));
endmodule

// File: rtl/dc_fifo_flags.sv
`timescale 1ns/1ps
module dc_fifo_flags #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = dcf_pkg::DATA_W
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic [AW-1:0] af_ofs_i,
  input  logic [AW-1:0] ae_ofs_i,
  input  logic          wen_ni,
  input  logic [DW-1:0] wdata_i,
  output logic          full_no,
  output logic          paf_no,
  output logic          hf_no,
  input  logic          ren_ni,
  output logic [DW-1:0] rdata_o,
  output logic          empty_no,
  output logic          pae_no
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned PW    = AW + 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] mem_rdata;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic          we;

  always_ff @(posedge wclk_i) begin
    if (we) mem_q[waddr] <= wdata_i;
  end
  assign mem_rdata = mem_q[raddr];

  dcf_sync #(.W(PW), .STAGES(2)) u_sync_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray), .q_o(wgray_s));

  dcf_sync #(.W(PW), .STAGES(2)) u_sync_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rgray), .q_o(rgray_s));

  dcf_wr_ctl #(.AW(AW)) u_wr (
    .clk_i(wclk_i), .rst_ni(rst_ni), .wen_ni(wen_ni), .af_ofs_i(af_ofs_i),
    .rgray_s_i(rgray_s), .we_o(we), .waddr_o(waddr), .wgray_o(wgray),
    .full_no(full_no), .paf_no(paf_no), .hf_no(hf_no));

  dcf_rd_ctl #(.AW(AW), .DW(DW)) u_rd (
    .clk_i(rclk_i), .rst_ni(rst_ni), .ren_ni(ren_ni), .fwft_i(fwft_i),
    .ae_ofs_i(ae_ofs_i), .wgray_s_i(wgray_s), .mem_rdata_i(mem_rdata),
    .raddr_o(raddr), .rgray_o(rgray), .rdata_o(rdata_o),
    .empty_no(empty_no), .pae_no(pae_no));
endmodule

// File: tb/dc_fifo_flags_test.sv
`timescale 1ns/1ps
module dc_fifo_flags_test;
  localparam int AW = 4;
  localparam int DW = 9;
  localparam int D  = 1 << AW;

  logic          wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic          fwft = 1'b0, wen_n = 1'b1, ren_n = 1'b1;
  logic [AW-1:0] af_ofs = '0, ae_ofs = '0;
  logic [DW-1:0] wdata = '0;
  logic          full_no, paf_no, hf_no, empty_no, pae_no;
  logic [DW-1:0] rdata_o;

  int nchk = 0, nbad = 0, occ = 0;
  int fw = 0, m = 0, n = 0;
  logic [DW-1:0] sb_q [$];

  always #2   wclk = ~wclk;   // 250 MHz write clock
  always #3.5 rclk = ~rclk;   // unrelated read clock

  dc_fifo_flags #(.AW(AW), .DW(DW)) uut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .fwft_i(fwft),
    .af_ofs_i(af_ofs), .ae_ofs_i(ae_ofs), .wen_ni(wen_n), .wdata_i(wdata),
    .full_no(full_no), .paf_no(paf_no), .hf_no(hf_no), .ren_ni(ren_n),
    .rdata_o(rdata_o), .empty_no(empty_no), .pae_no(pae_no));

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: one write attempt, pushes expected word when accepted
  task automatic wr(input logic [DW-1:0] d, output bit ok);
    @(negedge wclk);
    ok = full_no;
    wen_n = 1'b0;
    wdata = d;
    @(negedge wclk);
    wen_n = 1'b1;
    if (ok) begin
      sb_q.push_back(d);
      occ++;
    end
  endtask

  // monitor: one read attempt, pops and compares
  task automatic rd(output bit ok);
    logic [DW-1:0] exp_d;
    exp_d = '0;
    @(negedge rclk);
    ok = empty_no;
    if (ok) begin
      exp_d = sb_q.pop_front();
      occ--;
      if (fw != 0) chk("R8 head word visible before read", int'(rdata_o), int'(exp_d));
    end
    ren_n = 1'b0;
    @(negedge rclk);
    ren_n = 1'b1;
    if (ok && fw == 0) chk("R2 word order", int'(rdata_o), int'(exp_d));
  endtask

  task automatic settle;
    repeat (4) @(posedge wclk);
    repeat (4) @(posedge rclk);
    @(negedge wclk);
    #0.25;
  endtask

  task automatic check_flags(input string tag);
    chk({"R8 empty ", tag}, int'(empty_no), int'(occ != 0));
    chk({"R4 full ", tag}, int'(full_no), int'(occ != D + fw));
    chk({"R5 almost-full ", tag}, int'(paf_no), int'(occ < D + fw - m));
    chk({"R6 almost-empty ", tag}, int'(pae_no), int'(occ > n + fw));
    chk({"R7 half-full ", tag}, int'(hf_no), int'(occ < D / 2 + 1 + fw));
  endtask

  task automatic run_phase(input int f, input int mo, input int no);
    bit ok;
    fw = f; m = mo; n = no;
    fwft = f[0];
    af_ofs = mo[AW-1:0];
    ae_ofs = no[AW-1:0];
    wen_n = 1'b1;
    ren_n = 1'b1;
    sb_q.delete();
    occ = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge rclk);
    @(negedge wclk);
    #0.25;
    chk("R1 reset empty", int'(empty_no), 0);
    chk("R1 reset almost-empty", int'(pae_no), 0);
    chk("R1 reset full", int'(full_no), 1);
    chk("R1 reset almost-full", int'(paf_no), 1);
    chk("R1 reset half-full", int'(hf_no), 1);
    rst_n = 1'b1;
    settle;
    check_flags("R1 after reset release");
    // slow fill, every level checked
    for (int i = 0; i < D + f; i++) begin
      wr(DW'(i * 37 + f * 5 + mo), ok);
      chk("R2 write accepted", int'(ok), 1);
      settle;
      check_flags("R10 fill");
    end
    wr(9'h1AA, ok);
    chk("R3 full seen at write", int'(ok), 0);
    settle;
    check_flags("R3 after write while full");
    // slow drain, every level checked; order proves dropped write left no trace
    while (occ > 0) begin
      rd(ok);
      settle;
      check_flags("R10 drain");
    end
    rd(ok);
    chk("R3 empty seen at read", int'(ok), 0);
    settle;
    check_flags("R3 after read while empty");
    wr(9'h0C3, ok);
    settle;
    rd(ok);
    chk("R3 pointer unmoved by empty read", int'(ok), 1);
    settle;
    // concurrent stream with flag backpressure
    fork
      begin
        bit okw;
        int c;
        c = 0;
        while (c < 40) begin
          wr(DW'(c * 11 + 3), okw);
          if (okw) c++;
        end
      end
      begin
        bit okr;
        int c;
        c = 0;
        while (c < 40) begin
          rd(okr);
          if (okr) c++;
        end
      end
    join
    settle;
    check_flags("R2 after stream");
    chk("R2 scoreboard drained", sb_q.size(), 0);
  endtask

  initial begin
    run_phase(0, 3, 2);
    run_phase(1, 0, 0);
    run_phase(1, 5, 4);
    run_phase(0, 0, 0);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    #800000;
    nchk++;
    nbad++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule